// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

The block derives the card bus clock from a reference clock by an even division, and gates it on or off. The divider value and the gate enable arrive from the register side as staged values. They reach the clock generator only when the register side writes a command word that asks for a clock-only update. The command's start bit reads back high while that update is pending and clears by itself once the new settings are in force.

An update is applied only at a safe point: at the end of a low phase of the card clock, or at any time while the clock is gated or bypassed. A high phase is therefore never cut short. When the data path is busy, an update that carries the wait-for-previous-data bit is held until the busy flag drops. A second update request while one is still pending is refused, as is a request made during a busy period without the wait bit. Either refusal raises a sticky hardware-locked error flag, which the register side clears by writing a one to it.

Top module: `card_clk_div`

## Requirements
- R1: With a divider value N in 1..255 and the clock enabled, the card clock is high for N reference cycles and low for N reference cycles, so its frequency is the reference frequency divided by 2N.
- R2: With a divider value of 0 and the clock enabled, the card clock follows the reference clock.
- R3: The command word has the start bit at bit 2, update-only at bit 1 and wait-for-data at bit 0. A command write with bits 2 and 1 both set captures the staged divider and enable, and start_o is 1 from the next cycle until the capture is applied, after which it returns to 0. A command write with either bit clear leaves start_o and hle_o unchanged.
- R4: While data_busy_i is 1, an accepted update that has the wait bit set stays pending, with start_o held at 1. It applies after data_busy_i falls.
- R5: An update request made while start_o is 1, or made while data_busy_i is 1 with the wait bit clear, is refused. It sets hle_o from the next cycle, and it neither replaces the pending capture nor starts a new one.
- R6: hle_o stays set until a cycle with hle_clr_i at 1, after which it is 0. If a refusal occurs in the same cycle, the set takes priority.
- R7: Changes on div_i or clk_en_i that are not captured by an accepted command, including changes made while an update is pending, do not alter the card clock.
- R8: An update with the enable at 0 holds the card clock low. A later update with the enable at 1 makes it toggle again.
- R9: In divided mode, a new divider takes effect only while the card clock is low, and the first low phase after it lasts the new N cycles, so no shortened high pulse appears.
- R10: After reset the card clock is low and gated, the active divider is 1, and start_o and hle_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | Staged divider value |
| clk_en_i | input | 1 | Staged card clock enable |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_i | input | 3 | Command word: [2] start, [1] update-only, [0] wait-for-data |
| data_busy_i | input | 1 | Data path busy |
| hle_clr_i | input | 1 | Write-one-to-clear for the error flag |
| card_clk_o | output | 1 | Card bus clock |
| start_o | output | 1 | Update pending |
| hle_o | output | 1 | Hardware-locked error flag |

## Verification
The hardest state to reach is a deferred update that is still pending. In that state the bench must show three things: a second request is refused, a clear arriving in the same cycle as a refusal loses, and the staged inputs can change without effect. The bench holds data_busy_i high across an accepted update that has the wait bit set, and it performs each of these actions while start_o stays up. It then drops the busy flag and measures the resulting high and low phase widths, which proves that the capture made at acceptance was the one applied.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;
  localparam int CMD_W = 3;
  typedef struct packed {
    logic start;
    logic upd_only;
    logic wait_prv;
  } ccd_cmd_t;
endpackage

// File: rtl/card_clk_div_ctrl.sv
module card_clk_div_ctrl
  import card_clk_div_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  ccd_cmd_t         cmd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic             safe_i,
  input  logic             hle_clr_i,
  output logic             start_o,
  output logic             hle_o,
  output logic             apply_o,
  output logic [DIV_W-1:0] stg_div_o,
  output logic             stg_en_o
);
  logic req, reject, accept, pend_q, hle_q;

  assign req     = cmd_wr_i & cmd_i.start & cmd_i.upd_only;
  assign reject  = req & (pend_q | (busy_i & ~cmd_i.wait_prv));
  assign accept  = req & ~reject;
  assign apply_o = pend_q & ~busy_i & safe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      hle_q     <= 1'b0;
      stg_div_o <= '0;
      stg_en_o  <= 1'b0;
    end else begin
      if (accept) begin
        pend_q    <= 1'b1;
        stg_div_o <= div_i;
        stg_en_o  <= en_i;
      end else if (apply_o) begin
        pend_q <= 1'b0;
      end
      // set wins over clear
      if (reject)         hle_q <= 1'b1;
      else if (hle_clr_i) hle_q <= 1'b0;
    end
  end

  assign start_o = pend_q;
  assign hle_o   = hle_q;
endmodule

// File: rtl/card_clk_div_gen.sv
module card_clk_div_gen #(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  output logic             safe_o,
  output logic             card_clk_o,
  output logic             clk_q_o,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             en_q, clk_q, bypass, last;

  assign bypass = (div_q == '0);
  assign last   = (cnt_q == DIV_W'(div_q - 1'b1));
  // low-phase end, gated or bypassed: no high pulse gets truncated
  assign safe_o = ~en_q | bypass | (~clk_q & last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(RST_DIV);
      en_q  <= 1'b0;
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (apply_i) begin
      div_q <= div_i;
      en_q  <= en_i;
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_q || bypass) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (last) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign card_clk_o = bypass ? (en_q & clk_i) : clk_q;
  assign clk_q_o    = clk_q;
  assign div_o      = div_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_div_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clk_en_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             data_busy_i,
  input  logic             hle_clr_i,
  output logic             card_clk_o,
  output logic             start_o,
  output logic             hle_o
);
  ccd_cmd_t         cmd;
  logic             apply, safe, stg_en, gen_clk;
  logic [DIV_W-1:0] stg_div, act_div;

  assign cmd = cmd_i;

  card_clk_div_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr_i),
    .cmd_i     (cmd),
    .div_i     (div_i),
    .en_i      (clk_en_i),
    .busy_i    (data_busy_i),
    .safe_i    (safe),
    .hle_clr_i (hle_clr_i),
    .start_o   (start_o),
    .hle_o     (hle_o),
    .apply_o   (apply),
    .stg_div_o (stg_div),
    .stg_en_o  (stg_en)
  );

  card_clk_div_gen #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .apply_i    (apply),
    .div_i      (stg_div),
    .en_i       (stg_en),
    .safe_o     (safe),
    .card_clk_o (card_clk_o),
    .clk_q_o    (gen_clk),
    .div_o      (act_div)
  );
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr_i,
  input logic [2:0]       cmd_i,
  input logic             data_busy_i,
  input logic             hle_clr_i,
  input logic             start_o,
  input logic             hle_o,
  input logic             gen_clk,
  input logic [DIV_W-1:0] act_div
);
  a_r9_no_runt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div != $past(act_div)) |-> !$past(gen_clk));

  a_r4_defer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && data_busy_i) |=> start_o);

  a_r3_start_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(cmd_wr_i && cmd_i[2] && cmd_i[1]));

  a_r5_reject_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && cmd_wr_i && cmd_i[2] && cmd_i[1]) |=> hle_o);

  a_r6_hle_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hle_o && !hle_clr_i) |=> hle_o);

  a_r6_fall_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hle_o) |-> $past(hle_clr_i));
endmodule

bind card_clk_div card_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_wr_i    (cmd_wr_i),
  .cmd_i       (cmd_i),
  .data_busy_i (data_busy_i),
  .hle_clr_i   (hle_clr_i),
  .start_o     (start_o),
  .hle_o       (hle_o),
  .gen_clk     (gen_clk),
  .act_div     (act_div)
);

// File: tb/card_clk_div_bench.sv
module card_clk_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'd1, 8'd2, 8'd3, 8'd7, 8'd16, 8'd255};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       clk_en_i = 1'b0;
  logic       cmd_wr_i = 1'b0;
  logic [2:0] cmd_i = 3'b000;
  logic       data_busy_i = 1'b0;
  logic       hle_clr_i = 1'b0;
  logic       card_clk_o, start_o, hle_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  card_clk_div u_card_clk_div (
    .clk_i, .rst_ni, .div_i, .clk_en_i, .cmd_wr_i, .cmd_i,
    .data_busy_i, .hle_clr_i, .card_clk_o, .start_o, .hle_o
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] d, input logic en, input logic [2:0] c);
    div_i    = d;
    clk_en_i = en;
    cmd_i    = c;
    cmd_wr_i = 1'b1;
    tick(1);
    cmd_wr_i = 1'b0;
    cmd_i    = 3'b000;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 3000 && start_o; n++) tick(1);
  endtask

  task automatic measure(output int hi, output int lo);
    logic prev;
    hi = 0;
    lo = 0;
    prev = card_clk_o;
    for (int n = 0; n < 1200; n++) begin
      tick(1);
      if (!prev && card_clk_o) break;
      prev = card_clk_o;
    end
    for (int n = 0; n < 1200 && card_clk_o; n++) begin hi++; tick(1); end
    for (int n = 0; n < 1200 && !card_clk_o; n++) begin lo++; tick(1); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, lo, seen;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R10 reset state
    chk(start_o == 1'b0, "R10 start", start_o, 0);
    chk(hle_o == 1'b0, "R10 hle", hle_o, 0);
    seen = 0;
    for (int n = 0; n < 20; n++) begin tick(1); seen += card_clk_o; end
    chk(seen == 0, "R10 gated", seen, 0);

    // R1 divider table
    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v], 1'b1, 3'b111);
      chk(start_o == 1'b1, "R3 pending", start_o, 1);
      wait_done();
      chk(start_o == 1'b0, "R3 self clear", start_o, 0);
      measure(hi, lo);
      chk(hi == int'(VEC[v]), "R1 high", hi, VEC[v]);
      chk(lo == int'(VEC[v]), "R1 low", lo, VEC[v]);
    end

    // R7 staged change without command, R3 incomplete command ignored
    issue(8'd3, 1'b1, 3'b111);
    wait_done();
    div_i = 8'd5;
    issue(8'd5, 1'b1, 3'b101);
    chk(start_o == 1'b0, "R3 no upd-only", start_o, 0);
    issue(8'd5, 1'b1, 3'b011);
    chk(start_o == 1'b0, "R3 no start", start_o, 0);
    chk(hle_o == 1'b0, "R3 no hle", hle_o, 0);
    measure(hi, lo);
    chk(hi == 3, "R7 unchanged", hi, 3);

    // R8 disable and re-enable
    issue(8'd3, 1'b0, 3'b111);
    wait_done();
    seen = 0;
    for (int n = 0; n < 20; n++) begin tick(1); seen += card_clk_o; end
    chk(seen == 0, "R8 gated low", seen, 0);
    issue(8'd2, 1'b1, 3'b111);
    wait_done();
    measure(hi, lo);
    chk(hi == 2 && lo == 2, "R8 resumed", hi, 2);

    // R4 deferral with busy, R5 reject while pending, R6 clear
    data_busy_i = 1'b1;
    issue(8'd6, 1'b1, 3'b111);
    tick(50);
    chk(start_o == 1'b1, "R4 deferred", start_o, 1);
    issue(8'd9, 1'b1, 3'b111);
    chk(hle_o == 1'b1, "R5 pending reject", hle_o, 1);
    chk(start_o == 1'b1, "R5 still pending", start_o, 1);
    div_i = 8'd11;
    hle_clr_i = 1'b1;
    tick(1);
    hle_clr_i = 1'b0;
    chk(hle_o == 1'b0, "R6 cleared", hle_o, 0);
    hle_clr_i = 1'b1;
    issue(8'd12, 1'b1, 3'b111);
    hle_clr_i = 1'b0;
    chk(hle_o == 1'b1, "R6 set wins", hle_o, 1);
    hle_clr_i = 1'b1;
    tick(1);
    hle_clr_i = 1'b0;
    data_busy_i = 1'b0;
    wait_done();
    chk(start_o == 1'b0, "R4 applied", start_o, 0);
    measure(hi, lo);
    chk(hi == 6 && lo == 6, "R7 captured value", hi, 6);

    // R5 busy without wait bit
    data_busy_i = 1'b1;
    issue(8'd2, 1'b1, 3'b110);
    chk(hle_o == 1'b1, "R5 busy reject", hle_o, 1);
    chk(start_o == 1'b0, "R5 no pending", start_o, 0);
    hle_clr_i = 1'b1;
    tick(1);
    hle_clr_i = 1'b0;
    data_busy_i = 1'b0;
    measure(hi, lo);
    chk(hi == 6, "R5 clock kept", hi, 6);

    // R2 bypass
    issue(8'd0, 1'b1, 3'b111);
    wait_done();
    tick(1);
    seen = 0;
    for (int n = 0; n < 8; n++) begin
      @(posedge clk_i); #1;
      if (card_clk_o !== 1'b1) seen++;
      @(negedge clk_i); #1;
      if (card_clk_o !== 1'b0) seen++;
    end
    chk(seen == 0, "R2 follows ref", seen, 0);

    // R9 leave bypass, first phases match new divider
    tick(1);
    issue(8'd4, 1'b1, 3'b111);
    wait_done();
    measure(hi, lo);
    chk(hi == 4 && lo == 4, "R9 new divider", hi, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule